// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Parallel Read Port

This block is the digital half of a 12-bit successive-approximation converter that sits on a microprocessor-style parallel bus. It watches chip select, read strobe and a high-byte selector. A falling read strobe with the right qualifiers starts a conversion. It then runs the bit trials one clock at a time against a single comparator input, presents each trial code to the analog array, and holds a busy line low until the result is ready.

The host reads the result through the same strobe. A 16-bit or wider host takes the whole word in one read with the selector low. An 8-bit host reads the low eight lanes twice, once with the selector low and once with it high, and the second read places the upper result bits on the bottom lanes. After each conversion, a programmable acquisition window must pass before the sample-and-hold can be used again, and starts requested inside it are dropped. The bus inputs are assumed synchronous to the clock. The data lanes come out as a value plus a driver enable for the pad ring.

Top module: `sar_bus_ctrl`

## Requirements
- R1: When the read strobe goes from high to low between two clock samples while chip select is low and the high-byte selector is low, the converter is idle and no acquisition window is open, a conversion starts, and busy_n is low after that clock edge.
- R2: With chip select high, read strobe activity starts nothing and leaves the data driver enable low.
- R3: With the high-byte selector high, a falling read strobe never starts a conversion.
- R4: busy_n stays low for exactly 12 clock cycles per conversion.
- R5: Trials run MSB first. The first trial code is 0x800. Each following edge keeps the current trial bit when the comparator input is 1, clears it when the comparator input is 0, and sets the next lower bit. The trial code returns to 0 after the last decision.
- R6: The stored result equals the code reached after the 12th decision. For a comparator that reports 1 whenever the trial code is at or below an input value, the result equals that value.
- R7: A start request made while busy_n is low is ignored.
- R8: For ACQ_CYCLES clock edges after the one that ends a conversion (default 50), start requests are ignored. The first edge after that window may start a conversion.
- R9: data_oe is 1 exactly when chip select and read strobe are both low. While data_oe is 0, data_o is all zeros.
- R10: During a read with the selector low, data_o carries the full 12-bit result. With the selector high, data_o[3:0] carries result bits 11..8 and data_o[11:4] is zero.
- R11: A read during a conversion returns the previous completed result.
- R12: After reset, busy_n is high, data_oe is low, the trial code is 0 and the stored result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low; its falling edge requests a start |
| hben | input | 1 | High-byte selector; also blocks starts while high |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| trial_code | output | 12 | Code applied to the capacitor array |
| busy_n | output | 1 | Low while a conversion is in progress |
| data_o | output | 12 | Value for the data lanes |
| data_oe | output | 1 | Enable for the data lane drivers |

## Verification
The hardest case to reach is a start request that lands exactly on the edge of the acquisition window. The block silently drops a request one cycle early and accepts it one cycle later, so only busy_n shows the difference. The stimulus waits for busy_n to rise, then issues one-cycle read pulses with a delay that steps past the window, and a cycle-accurate model decides for each one whether it should start. Reads in the middle of a conversion and reads with the high-byte selector set are mixed in to expose held results and the lane routing.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // What the data lanes carry for the current bus state
    typedef enum logic [1:0] {
        LANE_OFF  = 2'd0,
        LANE_WORD = 2'd1,
        LANE_HIGH = 2'd2
    } lane_mode_e;

    function automatic lane_mode_e decode_lane(input logic cs_n, input logic rd_n,
                                               input logic hben);
        if (cs_n || rd_n) return LANE_OFF;
        if (hben)         return LANE_HIGH;
        return LANE_WORD;
    endfunction

endpackage

// File: rtl/sar_start_gate.sv
module sar_start_gate #(
    parameter int ACQ_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic hben,
    input  logic conv_busy,
    input  logic conv_done,
    output logic start
);
    localparam int AW = $clog2(ACQ_CYCLES + 2);

    typedef struct packed {
        logic          rd_prev;
        logic [AW-1:0] acq;
    } gate_s;

    gate_s s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.rd_prev = rd_n;
        if (conv_done)
            s_d.acq = AW'(ACQ_CYCLES);
        else if (s_q.acq != '0)
            s_d.acq = s_q.acq - 1'b1;
    end

    // Falling strobe, selected, low byte, idle and sample-and-hold settled
    assign start = s_q.rd_prev && !rd_n && !cs_n && !hben
                   && !conv_busy && (s_q.acq == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.rd_prev <= 1'b1;
            s_q.acq     <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_ACQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.acq != '0) |-> !conv_busy);  // R8

    AST_DONE_LOADS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> (s_q.acq != '0) || (ACQ_CYCLES == 0));  // R8

endmodule

// File: rtl/sar_trial_seq.sv
module sar_trial_seq #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cmp_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] trial,
    output logic [W-1:0] result
);
    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic         busy;
        logic [W-1:0] mask;
        logic [W-1:0] code;
        logic [W-1:0] result;
    } seq_s;

    seq_s         s_d, s_q;
    logic [W-1:0] decided;

    always_comb begin
        s_d     = s_q;
        decided = cmp_in ? s_q.code : (s_q.code & ~s_q.mask);
        if (start) begin
            s_d.busy = 1'b1;
            s_d.mask = TOP_BIT;
            s_d.code = TOP_BIT;
        end else if (s_q.busy) begin
            if (s_q.mask[0]) begin
                s_d.result = decided;
                s_d.code   = '0;
                s_d.mask   = '0;
                s_d.busy   = 1'b0;
            end else begin
                s_d.mask = s_q.mask >> 1;
                s_d.code = decided | (s_q.mask >> 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy   = s_q.busy;
    assign done   = s_q.busy && s_q.mask[0];
    assign trial  = s_q.code;
    assign result = s_q.result;

    AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $onehot(s_q.mask));  // R5

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !s_q.mask[0]) |=> $stable(result));  // R11

    AST_TRIAL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (trial == '0) || busy);  // R5

endmodule

// File: rtl/sar_lane_mux.sv
module sar_lane_mux #(
    parameter int W      = 12,
    parameter int LANE_W = 8
) (
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic         hben,
    input  logic [W-1:0] result,
    output logic [W-1:0] data_o,
    output logic         data_oe
);
    import sar_pkg::*;

    localparam int HI_W = W - LANE_W;

    lane_mode_e mode;

    always_comb begin
        mode   = decode_lane(cs_n, rd_n, hben);
        data_o = '0;
        case (mode)
            LANE_WORD: data_o = result;
            LANE_HIGH: data_o[HI_W-1:0] = result[W-1:LANE_W];
            default:   data_o = '0;
        endcase
    end

    assign data_oe = (mode != LANE_OFF);

endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl #(
    parameter int RES_W      = 12,
    parameter int LANE_W     = 8,
    parameter int ACQ_CYCLES = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             hben,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial_code,
    output logic             busy_n,
    output logic [RES_W-1:0] data_o,
    output logic             data_oe
);
    localparam int IW = $clog2(ACQ_CYCLES + 3);

    logic             start;
    logic             conv_busy;
    logic             conv_done;
    logic [RES_W-1:0] result;

    sar_start_gate #(.ACQ_CYCLES(ACQ_CYCLES)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .hben      (hben),
        .conv_busy (conv_busy),
        .conv_done (conv_done),
        .start     (start)
    );

    sar_trial_seq #(.W(RES_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .cmp_in (cmp_in),
        .busy   (conv_busy),
        .done   (conv_done),
        .trial  (trial_code),
        .result (result)
    );

    sar_lane_mux #(.W(RES_W), .LANE_W(LANE_W)) u_mux (
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .hben    (hben),
        .result  (result),
        .data_o  (data_o),
        .data_oe (data_oe)
    );

    assign busy_n = !conv_busy;

    // Checker bookkeeping: length of the busy pulse and of the idle gap
    logic [7:0]    low_len_q;
    logic [IW-1:0] idle_len_q;
    logic          seen_done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_len_q   <= '0;
            idle_len_q  <= '0;
            seen_done_q <= 1'b0;
        end else begin
            low_len_q   <= busy_n ? 8'd0 : low_len_q + 8'd1;
            if (!busy_n)
                idle_len_q <= '0;
            else if (idle_len_q != IW'(ACQ_CYCLES + 1))
                idle_len_q <= idle_len_q + 1'b1;
            seen_done_q <= seen_done_q | (busy_n && (low_len_q != 8'd0));
        end
    end

    AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) |-> $past(!cs_n && !rd_n && !hben));  // R1 R2 R3

    AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) |-> (trial_code == {1'b1, {(RES_W-1){1'b0}}}));  // R5

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (low_len_q == 8'(RES_W)));  // R4

    AST_ACQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_n) && seen_done_q) |-> (idle_len_q == IW'(ACQ_CYCLES + 1)));  // R8

    AST_HIGH_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && hben) |-> (data_o[RES_W-1:RES_W-LANE_W] == '0));  // R10

endmodule

// File: tb/test_sar_bus_ctrl.sv
`timescale 1ns/1ps
module test_sar_bus_ctrl;
    localparam int ACQ = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        hben = 1'b0;
    logic        cmp_in;
    logic [11:0] trial_code;
    logic        busy_n;
    logic [11:0] data_o;
    logic        data_oe;
    logic [11:0] vin = 12'd0;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    // Ideal comparator: 1 when the trial code is at or below the input
    assign cmp_in = (trial_code <= vin);

    sar_bus_ctrl #(.RES_W(12), .LANE_W(8), .ACQ_CYCLES(ACQ)) i_sar_bus_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .hben       (hben),
        .cmp_in     (cmp_in),
        .trial_code (trial_code),
        .busy_n     (busy_n),
        .data_o     (data_o),
        .data_oe    (data_oe)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_busy = 0;
    int m_acq = 0;
    int m_trial = 0;
    int m_mask = 0;
    int m_res = 0;
    int m_prev_rd = 1;
    bit m_live = 0;

    function automatic int exp_data();
        if (cs_n || rd_n) return 0;
        if (hben) return (m_res >> 8) & 'hF;
        return m_res;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_acq = 0; m_trial = 0; m_mask = 0; m_res = 0; m_prev_rd = 1;
        end else begin
            bit go;
            int kept;
            go = (m_prev_rd == 1) && !rd_n && !cs_n && !hben && (m_busy == 0) && (m_acq == 0);
            if (m_busy != 0) begin
                kept = (m_trial <= int'(vin)) ? m_trial : (m_trial - m_mask);
                if (m_mask == 1) begin
                    m_res = kept; m_trial = 0; m_mask = 0; m_busy = 0; m_acq = ACQ;
                end else begin
                    m_mask = m_mask >> 1;
                    m_trial = kept + m_mask;
                end
            end else if (m_acq > 0) begin
                m_acq--;
            end
            if (go) begin
                m_busy = 1; m_trial = 'h800; m_mask = 'h800;
            end
            m_prev_rd = rd_n ? 1 : 0;
            m_live = 1;
        end
        #5;
        if (rst_n && m_live) begin
            check("R1 R2 R3 R4 R7 R8 busy_n", int'(busy_n), (m_busy == 0) ? 1 : 0);
            check("R5 trial_code", int'(trial_code), m_trial);
            check("R9 data_oe", int'(data_oe), (!cs_n && !rd_n) ? 1 : 0);
            check("R6 R10 R11 data_o", int'(data_o), exp_data());
        end
    end

    // One read strobe of n cycles, driven from a falling clock edge
    task automatic pulse(input logic c, input logic h, input int n);
        cs_n = c; hben = h; rd_n = 1'b0;
        repeat (n) @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1; hben = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (!busy_n) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 busy_n in reset", int'(busy_n), 1);
        check("R12 data_oe in reset", int'(data_oe), 0);
        check("R12 trial_code in reset", int'(trial_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: stored result is 0, read through the high lanes (no start)
        cs_n = 0; hben = 1; rd_n = 0; #1;
        check("R12 R10 result after reset", int'(data_o), 0);
        @(negedge clk); rd_n = 1; cs_n = 1; hben = 0;
        @(negedge clk);

        // R1 R6: first conversion
        vin = 12'hA5C;
        pulse(1'b0, 1'b0, 2);
        check("R1 busy_n low after start", int'(busy_n), 0);
        repeat (14) @(negedge clk);
        check("R4 busy_n back high", int'(busy_n), 1);
        cs_n = 0; hben = 1; rd_n = 0; #1;
        check("R10 high byte read", int'(data_o), 'h00A);
        @(negedge clk); rd_n = 1; cs_n = 1; hben = 0;

        // R2: chip select high, strobe ignored
        repeat (ACQ + 2) @(negedge clk);
        pulse(1'b1, 1'b0, 2);
        check("R2 no start with cs high", int'(busy_n), 1);
        check("R2 no drive with cs high", int'(data_oe), 0);
        // R3: selector high, no start
        pulse(1'b0, 1'b1, 2);
        check("R3 no start with selector high", int'(busy_n), 1);

        // R11 R7: new conversion, read during it
        vin = 12'h3F1;
        pulse(1'b0, 1'b0, 1);
        check("R1 second start", int'(busy_n), 0);
        @(negedge clk);
        cs_n = 0; rd_n = 0; #1;
        check("R11 old result during conversion", int'(data_o), 'hA5C);
        @(negedge clk); rd_n = 1; cs_n = 1;
        @(negedge clk);
        pulse(1'b0, 1'b0, 1);
        wait_idle();
        cs_n = 0; rd_n = 0; #1;
        check("R6 result 0x3F1", int'(data_o), 'h3F1);
        @(negedge clk); rd_n = 1; cs_n = 1;

        // R8: request right after completion is dropped
        @(negedge clk);
        pulse(1'b0, 1'b0, 1);
        check("R8 start inside window ignored", int'(busy_n), 1);

        // R8 boundary sweep and extreme codes
        for (int k = 0; k < 8; k++) begin
            wait_idle();
            vin = (k % 2 == 0) ? 12'hFFF : 12'h000;
            repeat (ACQ - 4 + k) @(negedge clk);
            for (int j = 0; j < 4; j++) pulse(1'b0, 1'b0, 1);
        end
        wait_idle();
        repeat (ACQ + 2) @(negedge clk);
        cs_n = 0; rd_n = 0; hben = 1; #1;
        check("R10 high byte of last result", int'(data_o), (m_res >> 8) & 'hF);
        @(negedge clk); rd_n = 1; cs_n = 1; hben = 0;

        // Varied codes
        for (int k = 0; k < 6; k++) begin
            vin = 12'(k * 12'h2A7 + 12'h15);
            repeat (ACQ + 2) @(negedge clk);
            pulse(1'b0, 1'b0, 1);
            wait_idle();
            cs_n = 0; rd_n = 0; #1;
            check("R6 converted value", int'(data_o), int'(vin));
            @(negedge clk); rd_n = 1; cs_n = 1;
        end
        repeat (4) @(negedge clk);
        summary();
    end
endmodule